// File: doc/BRIEF.md
# Word Clock Resynchronizer and Rate Detector

This block sits between a serial audio input, which delivers one sample per word clock period, and an internal noise shaper that runs on the system clock. The sample is first captured on the word clock. It is then moved into the system clock domain on an internal load strobe. That strobe comes from the word clock itself, after the word clock has passed a two-flop synchronizer, so the strobe follows the word clock's phase at all times. Any early or late word edge restarts the internal timing at that edge.

The block runs on an internal tick. The tick fires every input clock cycle in divide-by-one mode and every second cycle in divide-by-two mode. Between word clock edges the block counts these ticks. A count that is a multiple of eight and within range gives the oversampling factor n, which is the count divided by eight. From n the block produces a rate enable that fires n times per word, one pulse every eight ticks, and the first pulse of each word falls on the word edge. A count that cannot be used raises an error flag and leaves the last good n in place.

Top module: `wck_resync_rate`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_in`, the next state is: `smp_out` = 0, `n_factor` = 0, `rate_en` = 0 and `rate_err` = 0.
- R2: When `div_one` = 1, the internal tick fires on every `clk_in` cycle. When `div_one` = 0, it fires on every second cycle. All counting is done in ticks, so n equals `clk_in` cycles per word divided by 8 in divide-by-one mode and divided by 16 in divide-by-two mode. In divide-by-two mode, `rate_en` is never high on two consecutive cycles.
- R3: The word clock passes two synchronizer flops and then an edge detector, all advanced by the tick. In divide-by-one mode, suppose `wck_in` rises between two `clk_in` edges. Then `smp_out` takes the value held on `wdata_in` at that rise on the third rising edge of `clk_in` after the rise.
- R4: At each recognised word edge after the first one, the block checks the number of ticks since the previous edge. If that number is a multiple of 8 and lies between 8 and 8×`NMAX` inclusive, `n_factor` becomes the number divided by 8 and `rate_err` clears. `n_factor` never exceeds `NMAX`.
- R5: At such an edge, if the number of ticks is not a multiple of 8 or is out of range, `rate_err` is set and `n_factor` keeps its previous value.
- R6: The first word edge after reset only starts the measurement. `n_factor` stays 0.
- R7: `rate_en` is a one-cycle pulse. It is registered on the tick of each recognised word edge and on every eighth tick after it. It is produced only while the previously held `n_factor` is non-zero. With a steady period of 8n ticks, exactly n pulses occur per word.
- R8: A word edge that arrives early or late restarts the eight-tick grid at that edge. Later pulses follow the new edge.
- R9: `smp_out` reloads at every recognised word edge. This includes edges that raise `rate_err` or change `n_factor`. At no other time does it change.
- R10: The tick counter saturates above 8×`NMAX`+7. A gap between word edges longer than that reports `rate_err` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_one | input | 1 | 1: internal tick every cycle; 0: tick every second cycle |
| wck_in | input | 1 | Word clock; the rising edge marks a new sample |
| wdata_in | input | DW | Sample, captured on the rising edge of `wck_in` |
| smp_out | output | DW | Sample resynchronized to the system clock |
| n_factor | output | NW | Measured oversampling factor, 0 until the first valid measurement |
| rate_en | output | 1 | Noise-shaper rate enable, n pulses per word |
| rate_err | output | 1 | Last measured word period was unusable |

## Verification
A wrong synchronizer or edge state shows up at `smp_out` in the word where it occurs. It appears as a load on the wrong cycle, or as a load that never happens. A wrong tick counter shows up at the next word edge, as a wrong `n_factor` or a wrong `rate_err`. A wrong phase counter shows up within eight ticks, as a `rate_en` pulse that is missing or misplaced. The behavioural reference model in the bench predicts all four outputs on every cycle. Any of these faults is therefore caught within one word period of the moment it arises.

// File: rtl/wrr_pkg.sv
// Shared constants for the word clock resynchronizer.
// Assumes PHASES is a power of two, so that the counters wrap naturally.
package wrr_pkg;
    // Internal ticks between two noise-shaper rate enables
    localparam int PHASES = 8;
    localparam int PH_W   = $clog2(PHASES);
endpackage

// File: rtl/wrr_edge_sync.sv
// Brings the asynchronous word clock into the system domain through STAGES
// flops and flags its rising edge for one tick.
// Assumes the word clock stays high and low for at least two ticks each.
module wrr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic tick,
    input  logic async_in,
    output logic rise
);
    // chain[STAGES] holds the previous synchronized level for edge detection
    logic [STAGES:0] chain;

    // Purpose: shift the word clock level through the synchronizer on each tick
    always_ff @(posedge clk_in) begin
        if (!rst_n) chain <= '0;
        else if (tick) chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = tick & chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/wrr_period_meter.sv
// Counts ticks between word edges and turns each period into the factor n.
// A period that is not a multiple of PHASES, or is out of range, sets the
// error flag and keeps the last good n. The first edge after reset only arms.
module wrr_period_meter
    import wrr_pkg::*;
#(
    parameter int NMAX = 32,
    parameter int NW   = 6
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rise,
    output logic [NW-1:0] n_q,
    output logic          err_q
);
    localparam int CMAX = PHASES * NMAX + PHASES;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          period_ok;

    assign period_ok = (cnt_q[PH_W-1:0] == '0)
                    && (cnt_q >= CW'(PHASES))
                    && (cnt_q <= CW'(PHASES * NMAX));

    // Purpose: count ticks since the last edge, saturating above the legal range
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (rise) cnt_q <= CW'(1);
            else if (cnt_q != CW'(CMAX)) cnt_q <= cnt_q + CW'(1);
        end
    end

    // Purpose: update n or raise the error flag at each armed word edge
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            n_q     <= '0;
            err_q   <= 1'b0;
            armed_q <= 1'b0;
        end else if (tick && rise) begin
            armed_q <= 1'b1;
            if (armed_q) begin
                if (period_ok) begin
                    n_q   <= NW'(cnt_q >> PH_W);
                    err_q <= 1'b0;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wrr_rate_strobe.sv
// Issues the noise-shaper rate enable on the edge tick and on every PHASES-th
// tick after it. Each word edge restarts the phase so the grid follows jitter.
// Assumes n_valid comes from a register (the previously held factor).
module wrr_rate_strobe
    import wrr_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    input  logic tick,
    input  logic rise,
    input  logic n_valid,
    output logic en_q
);
    logic [PH_W-1:0] pc_q;
    logic            slot;

    assign slot = rise | (pc_q == PH_W'(PHASES - 1));

    // Purpose: tick phase within the eight-tick grid, realigned on each edge
    always_ff @(posedge clk_in) begin
        if (!rst_n) pc_q <= '0;
        else if (tick) pc_q <= rise ? '0 : pc_q + PH_W'(1);
    end

    // Purpose: register a one-cycle rate enable on each grid slot
    always_ff @(posedge clk_in) begin
        if (!rst_n) en_q <= 1'b0;
        else en_q <= tick & slot & n_valid;
    end
endmodule

// File: rtl/wck_resync_rate.sv
// Top: captures the sample on the word clock, reloads it on the synchronized
// word edge, measures the oversampling factor and drives the rate enable.
// Assumes wdata_in is stable around the rising edge of wck_in.
module wck_resync_rate #(
    parameter  int DW          = 24,
    parameter  int NMAX        = 32,
    parameter  int SYNC_STAGES = 2,
    localparam int NW          = $clog2(NMAX + 1)
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          div_one,
    input  logic          wck_in,
    input  logic [DW-1:0] wdata_in,
    output logic [DW-1:0] smp_out,
    output logic [NW-1:0] n_factor,
    output logic          rate_en,
    output logic          rate_err
);
    logic          half_q;
    logic          tick;
    logic          word_rise;
    logic [DW-1:0] word_q;

    // Purpose: alternate the tick phase when dividing the clock by two
    always_ff @(posedge clk_in) begin
        if (!rst_n) half_q <= 1'b0;
        else half_q <= div_one ? 1'b0 : ~half_q;
    end

    assign tick = div_one | half_q;

    // Purpose: first register stage, in the word clock domain (data only, no reset)
    always_ff @(posedge wck_in) begin
        word_q <= wdata_in;
    end

    wrr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .tick    (tick),
        .async_in(wck_in),
        .rise    (word_rise)
    );

    // Purpose: second register stage, loaded on the synchronized word edge
    always_ff @(posedge clk_in) begin
        if (!rst_n) smp_out <= '0;
        else if (word_rise) smp_out <= word_q;
    end

    wrr_period_meter #(.NMAX(NMAX), .NW(NW)) i_meter (
        .clk_in(clk_in),
        .rst_n (rst_n),
        .tick  (tick),
        .rise  (word_rise),
        .n_q   (n_factor),
        .err_q (rate_err)
    );

    wrr_rate_strobe i_strobe (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .tick   (tick),
        .rise   (word_rise),
        .n_valid(n_factor != '0),
        .en_q   (rate_en)
    );
endmodule

// File: rtl/wrr_checker.sv
// Property checker for wck_resync_rate, attached with bind.
module wrr_checker #(
    parameter int DW   = 24,
    parameter int NW   = 6,
    parameter int NMAX = 32
) (
    input logic          clk_in,
    input logic          rst_n,
    input logic          div_one,
    input logic          rate_en,
    input logic          rate_err,
    input logic [NW-1:0] n_factor,
    input logic [DW-1:0] smp_out,
    input logic          edge_tick
);
    AST_HALF_RATE_GAP: assert property (@(posedge clk_in) disable iff (!rst_n)
        (rate_en && !div_one) |=> !rate_en);                       // R2
    AST_NEW_N_NO_ERR: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(n_factor) |-> !rate_err);                          // R4
    AST_N_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
        n_factor <= NW'(NMAX));                                     // R4
    AST_ERR_KEEPS_N: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(rate_err) |-> $stable(n_factor));                     // R5
    AST_EN_NEEDS_N: assert property (@(posedge clk_in) disable iff (!rst_n)
        rate_en |-> ($past(n_factor) != '0));                       // R7
    AST_SMP_ON_EDGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        !$stable(smp_out) |-> $past(edge_tick));                    // R9
endmodule

bind wck_resync_rate wrr_checker #(.DW(DW), .NW(NW), .NMAX(NMAX)) i_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .div_one  (div_one),
    .rate_en  (rate_en),
    .rate_err (rate_err),
    .n_factor (n_factor),
    .smp_out  (smp_out),
    .edge_tick(word_rise)
);

// File: tb/test_wck_resync_rate.sv
module test_wck_resync_rate;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 24;
    localparam int NMAX = 32;
    localparam int NW   = $clog2(NMAX + 1);
    localparam int CMAX = 8 * NMAX + 8;

    logic          clk_in   = 1'b0;
    logic          rst_n    = 1'b0;
    logic          div_one  = 1'b1;
    logic          wck_in   = 1'b0;
    logic [DW-1:0] wdata_in = '0;
    logic [DW-1:0] smp_out;
    logic [NW-1:0] n_factor;
    logic          rate_en;
    logic          rate_err;

    wck_resync_rate #(.DW(DW), .NMAX(NMAX)) i_wck_resync_rate (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .div_one (div_one),
        .wck_in  (wck_in),
        .wdata_in(wdata_in),
        .smp_out (smp_out),
        .n_factor(n_factor),
        .rate_en (rate_en),
        .rate_err(rate_err)
    );

    always #(CLK_PERIOD / 2) clk_in = ~clk_in;

    int vectors = 0;
    int fails   = 0;
    bit cmp_on  = 1'b0;
    bit run     = 1'b0;
    int wper    = 32;
    int wcnt    = 31;
    int unsigned seed = 32'h1234_5678;
    logic [DW-1:0] cap = '0;

    // Behavioural reference model, in ticks and word levels
    int m_half = 0, m_a = 0, m_b = 0, m_prev = 0;
    int m_cnt = 0, m_armed = 0, m_n = 0, m_err = 0, m_pc = 0, m_en = 0;
    logic [DW-1:0] m_smp = '0;

    always @(posedge clk_in) begin
        int ce;
        int ed;
        if (!rst_n) begin
            m_half = 0; m_a = 0; m_b = 0; m_prev = 0;
            m_cnt = 0; m_armed = 0; m_n = 0; m_err = 0; m_pc = 0; m_en = 0;
            m_smp = '0;
        end else begin
            ce = (div_one || m_half) ? 1 : 0;
            m_half = div_one ? 0 : (m_half ? 0 : 1);
            ed = (ce != 0 && m_b != 0 && m_prev == 0) ? 1 : 0;
            m_en = (ce != 0 && (ed != 0 || m_pc == 7) && m_n != 0) ? 1 : 0;
            if (ce != 0) begin
                m_prev = m_b; m_b = m_a; m_a = wck_in ? 1 : 0;
                if (ed != 0) begin
                    if (m_armed != 0) begin
                        if (m_cnt % 8 == 0 && m_cnt >= 8 && m_cnt <= 8 * NMAX) begin
                            m_n = m_cnt / 8; m_err = 0;
                        end else begin
                            m_err = 1;
                        end
                    end
                    m_armed = 1; m_cnt = 1; m_pc = 0; m_smp = cap;
                end else begin
                    if (m_cnt < CMAX) m_cnt++;
                    m_pc = (m_pc + 1) % 8;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_in);
        if (cmp_on) begin
            chk(smp_out == m_smp, "R3 R9 sample", smp_out, m_smp);
            chk(int'(n_factor) == m_n, "R4 R6 factor", n_factor, m_n);
            chk(int'(rate_en) == m_en, "R7 R8 rate enable", rate_en, m_en);
            chk(int'(rate_err) == m_err, "R5 R10 error", rate_err, m_err);
        end
        if (run) begin
            wcnt = (wcnt + 1 >= wper) ? 0 : wcnt + 1;
            if (wcnt == wper - 1) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                wdata_in = seed[DW-1:0];
            end
            wck_in = (wcnt < wper / 2);
            if (wcnt == 0) cap = wdata_in;
        end
    endtask

    task automatic set_period(input int p);
        while (wcnt != 0) step();
        wper = p;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        int c;
        wdata_in = 24'hA5C3E1;
        repeat (3) step();
        cmp_on = 1'b1;
        repeat (3) step();
        chk(smp_out == '0, "R1 reset sample", smp_out, 0);
        chk(n_factor == '0, "R1 reset factor", n_factor, 0);
        chk(rate_en == 1'b0, "R1 reset enable", rate_en, 0);
        chk(rate_err == 1'b0, "R1 reset error", rate_err, 0);
        rst_n = 1'b1;
        step();
        run = 1'b1;
        // R3: load lands on the third clock edge after the word clock rises
        while (wcnt != 2) step();
        chk(smp_out == '0, "R3 not loaded before third edge", smp_out, 0);
        step();
        chk(smp_out == 24'hA5C3E1, "R3 loaded on third edge", smp_out, 24'hA5C3E1);
        chk(n_factor == '0, "R6 first edge only arms", n_factor, 0);
        repeat (20 * 32) step();
        chk(n_factor == 4, "R4 factor for 32 clocks per word", n_factor, 4);
        chk(rate_err == 1'b0, "R4 error clear", rate_err, 0);
        c = 0;
        repeat (32) begin step(); if (rate_en) c++; end
        chk(c == 4, "R7 pulses per word", c, 4);
        set_period(24);
        repeat (10 * 24) step();
        chk(n_factor == 3, "R4 factor for 24 clocks per word", n_factor, 3);
        // R8: shorten one word by three cycles
        while (wcnt != 10) step();
        wcnt = 13;
        repeat (20) step();
        chk(rate_err == 1'b1, "R5 short word flagged", rate_err, 1);
        chk(n_factor == 3, "R5 factor held", n_factor, 3);
        repeat (24 * 3) step();
        chk(rate_err == 1'b0, "R8 recovers after realign", rate_err, 0);
        set_period(30);
        repeat (5 * 30) step();
        chk(rate_err == 1'b1, "R5 non-multiple period", rate_err, 1);
        chk(n_factor == 3, "R5 factor held", n_factor, 3);
        set_period(64);
        repeat (8 * 64) step();
        chk(n_factor == 8, "R4 factor for 64 clocks per word", n_factor, 8);
        div_one = 1'b0;
        set_period(96);
        repeat (6 * 96) step();
        chk(n_factor == 6, "R2 divide-by-two factor", n_factor, 6);
        chk(rate_err == 1'b0, "R2 divide-by-two error clear", rate_err, 0);
        c = 0;
        repeat (96) begin step(); if (rate_en) c++; end
        chk(c == 6, "R2 R7 pulses per word halved clock", c, 6);
        set_period(48);
        repeat (6 * 48) step();
        chk(n_factor == 3, "R2 divide-by-two 48 clocks", n_factor, 3);
        div_one = 1'b1;
        set_period(600);
        repeat (2 * 600 + 10) step();
        chk(rate_err == 1'b1, "R10 overlong period", rate_err, 1);
        chk(n_factor == 3, "R10 factor held", n_factor, 3);
        set_period(32);
        repeat (4 * 32) step();
        chk(n_factor == 4, "R4 factor after recovery", n_factor, 4);
        chk(rate_err == 1'b0, "R4 error clear after recovery", rate_err, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_in);
        vectors++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end
endmodule